// File: doc/BRIEF.md
# Serial Nonvolatile Byte Store (256 x 8, three-wire slave)

This block models a small serial nonvolatile memory of 256 bytes that sits behind a three-wire slave port. The port has an active-low select, a serial clock that idles high, a data input and a data output with a separate drive-enable that stands in for the high-impedance state. A fast system clock oversamples all three pins through a synchronizer and detects the serial clock edges. Input bits are taken on serial-clock rising edges, and output bits change on falling edges. An active-low reset clears the control state and leaves the block with writes locked.

Each frame carries an 8-bit address and then an 8-bit operation code. Depending on the code, the frame goes on to read a byte, stream bytes from consecutive addresses, accept a byte to program, clear the whole array, report write progress, or lock or unlock writes. A program or an array clear starts an internal timer of `WRITE_CYCLES` system clocks. While that timer runs, only progress polling is accepted. The storage has no reset, so its contents survive the reset pin.

The controller is one state machine with these states:
- **ST_WAIT**: the frame is finished or ignored; the block waits for select to go high.
- **ST_IDLE**: select is high.
- **ST_ADDR**: address bits are shifting in.
- **ST_CMD**: operation bits are shifting in.
- **ST_WDATA**: program data is shifting in.
- **ST_RDATA**: read data is shifting out.
- **ST_STATUS**: the progress level is being driven.

Transitions:
- Any state goes to ST_IDLE whenever select is high.
- ST_IDLE goes to ST_ADDR when select falls.
- ST_ADDR goes to ST_CMD after the 8th rising edge.
- On the 16th rising edge, ST_CMD decodes the operation:
  - a read or a sequential read goes to ST_RDATA;
  - a program with writes unlocked goes to ST_WDATA;
  - progress polling goes to ST_STATUS;
  - every other case goes to ST_WAIT.
- ST_WDATA goes to ST_WAIT on the 24th rising edge.
- ST_RDATA goes to ST_WAIT on the falling edge after the last bit of a single read.
- Reset enters ST_WAIT.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset the output drive-enable is low and writes are locked. A program issued before any unlock leaves the addressed byte unchanged.
- R2: A frame is 8 address bits, least significant first, then 8 operation bits. The operation codes are listed in wire order, first bit leftmost: read 10000000, program 01100000, clear-all 00110000, poll 10110000, unlock 10010000, lock 11010000, sequential read 10001000. Clear-all, poll, unlock and lock ignore the address bits.
- R3: For a read, the byte at the address is driven least significant bit first. Each bit is updated on a falling edge, starting with the falling edge after the 16th rising edge. The drive-enable drops on the falling edge after the 24th rising edge.
- R4: For a program with writes unlocked, the data byte (bit 0 first) taken on rising edges 17 to 24 is stored at the address. Select may rise while the write is still timing.
- R5: Clear-all with writes unlocked sets every byte to 0x00.
- R6: A sequential read keeps streaming. Each further 8 clocks output the next address, and address 255 is followed by address 0.
- R7: Poll drives the output low while a write or clear is timing and high after it ends. It holds that level until select rises, and it is accepted while busy.
- R8: While busy, every code except poll is ignored: a read drives nothing and a program stores nothing.
- R9: While writes are locked, program and clear-all store nothing. The lock state persists until an unlock or lock code changes it.
- R10: A program frame cut off by select rising before its 24th rising edge stores nothing.
- R11: An unknown operation code is ignored and the output stays undriven for the rest of the frame.
- R12: Serial clock edges while select is high have no effect, and the output is undriven while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset; locks writes and aborts any frame |
| sel_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in, sampled on serial-clock rising edges |
| sdo | output | 1 | Serial data out, updated on serial-clock falling edges |
| sdo_en | output | 1 | High while sdo is driven; low means high-impedance |

## Verification
The bench builds the block with `WRITE_CYCLES` = 400 and a serial bit period of about 13 system clocks. With these values a whole 16-bit poll or program frame fits inside one write interval. This makes it possible to observe the low progress level, to issue a second program and a read while the block is busy, and then to see the level turn high with select still low. The default address width of 8 keeps the full 256-entry array, so the wrap from 255 to 0 in a sequential read is exercised on real storage.

// File: rtl/snv_pkg.sv
package snv_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_STATUS
    } snv_state_e;

    // Operation codes as stored after shifting: bit 0 is the first bit on the wire.
    typedef enum logic [OP_W-1:0] {
        OP_READ  = 8'h01,
        OP_PROG  = 8'h06,
        OP_ERASE = 8'h0C,
        OP_POLL  = 8'h0D,
        OP_WREN  = 8'h09,
        OP_WRDIS = 8'h0B,
        OP_SEQRD = 8'h11
    } snv_op_e;

endpackage

// File: rtl/snv_pin_sync.sv
module snv_pin_sync #(
    parameter int          WIDTH    = 3,
    parameter int          STAGES   = 2,
    parameter logic [WIDTH-1:0] IDLE_LVL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= IDLE_LVL;
                else        stg <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{IDLE_LVL}};
                else        stg <= {stg[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign lvl_o = stg[STAGES-1];

endmodule

// File: rtl/snv_busy_timer.sv
module snv_busy_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             remain <= '0;
        else if (start_i)       remain <= TW'(CYCLES);
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/snv_store.sv
module snv_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic          clr_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // No reset: contents model nonvolatile cells.
    always_ff @(posedge clk) begin
        if (clr_i) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
    import snv_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 1250000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);

    localparam int CNT_W = $clog2(ADDR_W + OP_W + DATA_W);
    localparam int OB_W  = $clog2(DATA_W);
    localparam logic [OB_W-1:0] OB_LAST = OB_W'(DATA_W - 1);

    // ---------------- pin conditioning ----------------
    logic [2:0] pin_lvl;
    logic       sel_hi, sclk_lvl, sclk_prev, din;
    logic       sclk_r, sclk_f;

    snv_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .IDLE_LVL(3'b011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i({sdi, sclk, sel_n}),
        .lvl_o(pin_lvl)
    );

    assign sel_hi   = pin_lvl[0];
    assign sclk_lvl = pin_lvl[1];
    assign din      = pin_lvl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= sclk_lvl;
    end

    assign sclk_r = sclk_lvl & ~sclk_prev & ~sel_hi;
    assign sclk_f = ~sclk_lvl & sclk_prev & ~sel_hi;

    // ---------------- state and shift registers ----------------
    snv_state_e          state, nstate;
    logic [CNT_W-1:0]    cnt;
    logic [ADDR_W-1:0]   addr_sh;
    logic [OP_W-2:0]     op_sh;
    logic [DATA_W-2:0]   dat_sh;
    logic [ADDR_W-1:0]   rd_ptr;
    logic [OB_W-1:0]     obit;
    logic                byte_sent, seq_mode, wr_on;
    logic                sdo_q, sdo_en_q;
    logic                busy;
    logic [DATA_W-1:0]   rd_data;

    logic [OP_W-1:0]     cmd_word;
    snv_op_e             op;
    logic                hit_cmd, hit_data;
    logic                prog_go, erase_go;

    assign cmd_word = {din, op_sh};
    assign op       = snv_op_e'(cmd_word);
    assign hit_cmd  = (state == ST_CMD)   && sclk_r && (cnt == CNT_W'(OP_W - 1));
    assign hit_data = (state == ST_WDATA) && sclk_r && (cnt == CNT_W'(DATA_W - 1));
    assign prog_go  = hit_data;
    assign erase_go = hit_cmd && (op == OP_ERASE) && wr_on && !busy;

    // ---------------- next-state logic ----------------
    always_comb begin
        nstate = state;
        if (sel_hi) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_WAIT:   nstate = ST_WAIT;
                ST_IDLE:   nstate = ST_ADDR;
                ST_ADDR:   if (sclk_r && cnt == CNT_W'(ADDR_W - 1)) nstate = ST_CMD;
                ST_CMD: begin
                    if (hit_cmd) begin
                        if (busy && op != OP_POLL) begin
                            nstate = ST_WAIT;
                        end else begin
                            unique case (op)
                                OP_READ, OP_SEQRD: nstate = ST_RDATA;
                                OP_PROG:           nstate = wr_on ? ST_WDATA : ST_WAIT;
                                OP_POLL:           nstate = ST_STATUS;
                                default:           nstate = ST_WAIT;
                            endcase
                        end
                    end
                end
                ST_WDATA:  if (hit_data) nstate = ST_WAIT;
                ST_RDATA:  if (sclk_f && byte_sent && !seq_mode) nstate = ST_WAIT;
                ST_STATUS: nstate = ST_STATUS;
                default:   nstate = ST_WAIT;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nstate;
    end

    // ---------------- bit counter per phase ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (nstate != state)  cnt <= '0;
        else if (sclk_r)           cnt <= cnt + 1'b1;
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sh   <= '0;
            op_sh     <= '0;
            dat_sh    <= '0;
            rd_ptr    <= '0;
            obit      <= '0;
            byte_sent <= 1'b0;
            seq_mode  <= 1'b0;
            wr_on     <= 1'b0;
            sdo_q     <= 1'b0;
            sdo_en_q  <= 1'b0;
        end else begin
            if (sclk_r) begin
                if (state == ST_ADDR)  addr_sh <= {din, addr_sh[ADDR_W-1:1]};
                if (state == ST_CMD)   op_sh   <= {din, op_sh[OP_W-2:1]};
                if (state == ST_WDATA) dat_sh  <= {din, dat_sh[DATA_W-2:1]};
            end

            if (hit_cmd) begin
                rd_ptr    <= addr_sh;
                obit      <= '0;
                byte_sent <= 1'b0;
                seq_mode  <= (op == OP_SEQRD);
                if (!busy) begin
                    if (op == OP_WREN)  wr_on <= 1'b1;
                    if (op == OP_WRDIS) wr_on <= 1'b0;
                end
            end

            if (sel_hi) begin
                sdo_en_q <= 1'b0;
                sdo_q    <= 1'b0;
            end else if (state == ST_STATUS) begin
                sdo_en_q <= 1'b1;
                sdo_q    <= ~busy;
            end else if (state == ST_RDATA && sclk_f) begin
                if (byte_sent && !seq_mode) begin
                    sdo_en_q <= 1'b0;
                    sdo_q    <= 1'b0;
                end else begin
                    sdo_en_q <= 1'b1;
                    sdo_q    <= rd_data[obit];
                    if (obit == OB_LAST) begin
                        obit      <= '0;
                        rd_ptr    <= rd_ptr + 1'b1;
                        byte_sent <= 1'b1;
                    end else begin
                        obit <= obit + 1'b1;
                    end
                end
            end
        end
    end

    assign sdo    = sdo_q;
    assign sdo_en = sdo_en_q;

    // ---------------- write timer and storage ----------------
    snv_busy_timer #(
        .CYCLES(WRITE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(prog_go | erase_go),
        .busy_o (busy)
    );

    snv_store #(
        .AW(ADDR_W),
        .DW(DATA_W)
    ) u_store (
        .clk    (clk),
        .we_i   (prog_go),
        .clr_i  (erase_go),
        .waddr_i(addr_sh),
        .wdata_i({din, dat_sh}),
        .raddr_i(rd_ptr),
        .rdata_o(rd_data)
    );

endmodule

// File: rtl/snv_checker.sv
module snv_checker
    import snv_pkg::*;
#(
    parameter int WRITE_CYCLES = 1250000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_hi,
    input logic       sdo_en,
    input snv_state_e state,
    input logic       busy,
    input logic       wr_on,
    input logic       st_we,
    input logic       st_clr
);

    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R7: the progress level stays low for exactly WRITE_CYCLES clocks
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == WRITE_CYCLES);

    // R8: nothing is stored while a write is timing
    p_busy_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(st_we || st_clr));

    // R9: locked writes never reach the storage
    p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_on |-> !(st_we || st_clr));

    // R5: a clear and a byte write never coincide
    p_single_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_we, st_clr}));

    // R11: an ignored or finished frame leaves the output undriven
    p_wait_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sdo_en);

    // R12: deselect releases the output on the next clock
    p_desel_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi |=> !sdo_en);

endmodule

bind serial_nvm_slave snv_checker #(
    .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_hi(sel_hi),
    .sdo_en(sdo_en),
    .state (state),
    .busy  (busy),
    .wr_on (wr_on),
    .st_we (prog_go),
    .st_clr(erase_go)
);

// File: tb/serial_nvm_slave_tb.sv
module serial_nvm_slave_tb;

    localparam int WCYC = 400;
    localparam int HALF = 6;

    // Codes with bit 0 = first bit on the wire (R2)
    localparam logic [7:0] C_READ  = 8'b0000_0001;
    localparam logic [7:0] C_PROG  = 8'b0000_0110;
    localparam logic [7:0] C_ERASE = 8'b0000_1100;
    localparam logic [7:0] C_POLL  = 8'b0000_1101;
    localparam logic [7:0] C_WREN  = 8'b0000_1001;
    localparam logic [7:0] C_WRDIS = 8'b0000_1011;
    localparam logic [7:0] C_SEQ   = 8'b0001_0001;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, sel_n, sclk, sdi;
    logic sdo, sdo_en;

    serial_nvm_slave #(
        .WRITE_CYCLES(WCYC)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (sel_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .sdo   (sdo),
        .sdo_en(sdo_en)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    exp_t       mon_e;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         mon_on = 1'b0;
    logic [7:0] mon_sh = '0;
    int         mon_n = 0;
    logic       last_do, last_en;

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: collects driven bits at serial rising edges, compares whole bytes
    always @(posedge sclk) begin
        if (mon_on && sdo_en === 1'b1) begin
            mon_sh = {sdo, mon_sh[7:1]};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard unexpected byte", mon_sh, 8'h00);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(mon_sh === mon_e.val, mon_e.tag, mon_sh, mon_e.val);
                end
            end
        end
    end

    task automatic tick();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic b);
        @(negedge clk);
        sclk = 1'b0;
        sdi  = b;
        tick();
        last_do = sdo;
        last_en = sdo_en;
        sclk = 1'b1;
        tick();
    endtask

    task automatic send8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) xfer(v[i]);
    endtask

    task automatic open_frame();
        @(negedge clk);
        sel_n = 1'b0;
        tick();
    endtask

    task automatic close_frame();
        tick();
        sel_n = 1'b1;
        tick();
        tick();
    endtask

    task automatic cmd_only(input logic [7:0] a, input logic [7:0] c);
        open_frame();
        send8(a);
        send8(c);
        close_frame();
    endtask

    task automatic prog(input logic [7:0] a, input logic [7:0] d, input int nbits);
        logic [23:0] bits;
        bits = {d, C_PROG, a};
        open_frame();
        for (int i = 0; i < nbits; i++) xfer(bits[i]);
        close_frame();
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic read_frame(input logic [7:0] a, input int nbytes, input bit seq, input string tag);
        open_frame();
        send8(a);
        send8(seq ? C_SEQ : C_READ);
        mon_on = 1'b1;
        repeat (8 * nbytes) xfer(1'b0);
        mon_on = 1'b0;
        if (!seq) begin
            xfer(1'b0);
            check(last_en === 1'b0, {tag, " R3 release after last bit"}, {7'd0, last_en}, 8'h00);
        end
        close_frame();
        check(exp_q.size() == 0, {tag, " all bytes seen"}, 8'(exp_q.size()), 8'h00);
        exp_q.delete();
    endtask

    task automatic wait_ready();
        repeat (WCYC + 40) @(negedge clk);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit quiet;
        rst_n = 1'b0;
        sel_n = 1'b1;
        sclk  = 1'b1;
        sdi   = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(sdo_en === 1'b0, "R1 undriven after reset", {7'd0, sdo_en}, 8'h00);

        // R5 with R7: unlock, clear, poll while busy then after completion
        cmd_only(8'h00, C_WREN);
        cmd_only(8'h33, C_ERASE);
        open_frame();
        send8(8'h5A);
        send8(C_POLL);
        xfer(1'b0);
        check(last_en === 1'b1 && last_do === 1'b0, "R7 poll low while busy",
              {6'd0, last_en, last_do}, 8'h02);
        repeat (WCYC) @(negedge clk);
        check(sdo_en === 1'b1 && sdo === 1'b1, "R7 poll high and held after completion",
              {6'd0, sdo_en, sdo}, 8'h03);
        close_frame();
        check(sdo_en === 1'b0, "R7 released on deselect", {7'd0, sdo_en}, 8'h00);

        // R9: locked program stores nothing
        cmd_only(8'h00, C_WRDIS);
        prog(8'h10, 8'hA5, 24);
        wait_ready();
        expect_byte(8'h00, "R9 locked program ignored");
        read_frame(8'h10, 1, 1'b0, "R9");

        // R1: reset relocks after unlock
        cmd_only(8'h00, C_WREN);
        pulse_reset();
        prog(8'h20, 8'h5A, 24);
        wait_ready();
        expect_byte(8'h00, "R1 reset locks writes");
        read_frame(8'h20, 1, 1'b0, "R1");

        // R4 and R8: program, then a second program while busy
        cmd_only(8'h00, C_WREN);
        prog(8'h10, 8'hA5, 24);
        prog(8'h41, 8'h11, 24);
        wait_ready();

        // R8: read attempted while busy drives nothing
        prog(8'hFF, 8'hC3, 24);
        open_frame();
        send8(8'h10);
        send8(C_READ);
        quiet = 1'b1;
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0);
            if (last_en !== 1'b0) quiet = 1'b0;
        end
        close_frame();
        check(quiet, "R8 read while busy undriven", {7'd0, ~quiet}, 8'h00);
        wait_ready();

        prog(8'h11, 8'h96, 24);
        wait_ready();
        prog(8'h00, 8'h3C, 24);
        wait_ready();

        // R2, R3, R4: single reads at distinct addresses
        expect_byte(8'hA5, "R3 R4 read 0x10");
        read_frame(8'h10, 1, 1'b0, "R3");
        expect_byte(8'hC3, "R2 read 0xFF");
        read_frame(8'hFF, 1, 1'b0, "R2");
        expect_byte(8'h3C, "R2 read 0x00");
        read_frame(8'h00, 1, 1'b0, "R2");
        expect_byte(8'h00, "R8 program while busy ignored");
        read_frame(8'h41, 1, 1'b0, "R8");

        // R6: sequential read, plain and wrapping
        expect_byte(8'hA5, "R6 seq byte 0");
        expect_byte(8'h96, "R6 seq byte 1");
        expect_byte(8'h00, "R6 seq byte 2");
        read_frame(8'h10, 3, 1'b1, "R6");
        expect_byte(8'hC3, "R6 wrap byte 255");
        expect_byte(8'h3C, "R6 wrap byte 0");
        read_frame(8'hFF, 2, 1'b1, "R6 wrap");

        // R10: program cut off before bit 24
        prog(8'h50, 8'hEE, 20);
        wait_ready();
        expect_byte(8'h00, "R10 cut program discarded");
        read_frame(8'h50, 1, 1'b0, "R10");

        // R11: unknown code
        open_frame();
        send8(8'h10);
        send8(8'hFF);
        quiet = 1'b1;
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0);
            if (last_en !== 1'b0) quiet = 1'b0;
        end
        close_frame();
        check(quiet, "R11 unknown code undriven", {7'd0, ~quiet}, 8'h00);

        // R12: serial clock while deselected
        quiet = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            sclk = 1'b0;
            sdi  = 1'b1;
            tick();
            if (sdo_en !== 1'b0) quiet = 1'b0;
            sclk = 1'b1;
            tick();
        end
        check(quiet, "R12 undriven while deselected", {7'd0, ~quiet}, 8'h00);
        expect_byte(8'hA5, "R12 next frame unaffected");
        read_frame(8'h10, 1, 1'b0, "R12");

        // R9 persistence: clear blocked while locked, then R5 clear when unlocked
        cmd_only(8'h00, C_WRDIS);
        cmd_only(8'h00, C_ERASE);
        wait_ready();
        expect_byte(8'hA5, "R9 locked clear ignored");
        read_frame(8'h10, 1, 1'b0, "R9 clear");
        cmd_only(8'h00, C_WREN);
        cmd_only(8'h00, C_ERASE);
        wait_ready();
        expect_byte(8'h00, "R5 cleared 0xFF");
        expect_byte(8'h00, "R5 cleared 0x00");
        read_frame(8'hFF, 2, 1'b1, "R5");
        expect_byte(8'h00, "R5 cleared 0x10");
        read_frame(8'h10, 1, 1'b0, "R5 single");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule